// File: doc/BRIEF.md
# Two-Clock Simple Dual-Port RAM with Half-Cycle Read Option

This block is a word-addressed storage array with a write side and a read side. Each side has its own clock. Address, data and the enable on the write side are captured on the rising edge of the write clock. The word is committed to the array on the following write-clock edge. The read side is built in one of two variants, picked by the parameter `PSEUDO_ASYNC`.

With `PSEUDO_ASYNC = 0` the read address and read enable are sampled on the rising edge of the read clock. The word is then loaded into an output register on the next rising edge, so read data lags the address by two read-clock cycles. With `PSEUDO_ASYNC = 1` the read address is sampled on the falling edge of the read clock and the output register is left out. Data then shows up in the second half of the same cycle and tracks the array contents at the held address from then on. This suits a consumer that needs the word before its next rising edge, and it can tolerate the longer combinational path.

The default array holds 256 words of 16 bits. Both widths are parameters.

Top module: `split_clock_ram`

## Requirements
- R1: A write presented with `wrEn` high at a rising `wrClk` edge is stored at `wrAddr`. Every later read of that address returns the value, and writes take place while the read clock is stopped.
- R2: The read-side state and `rdData` change only through `rdClk` edges. Address and enable changes on the read port have no effect while `rdClk` is held low.
- R3: With `PSEUDO_ASYNC = 0`, a read address presented with `rdEn` high before rising edge E1 appears on `rdData` only after rising edge E2. The output is unchanged between E1 and E2.
- R4: With `PSEUDO_ASYNC = 1`, a read address presented with `rdEn` high after a rising edge is captured on the following falling edge. The word is on `rdData` before the next rising edge.
- R5: With `PSEUDO_ASYNC = 0`, when `rdEn` is low at the capturing edge, the output register keeps its previous value whatever `rdAddr` holds.
- R6: With `PSEUDO_ASYNC = 1`, when `rdEn` is low at the falling edge, the captured address is kept. `rdData` then follows the array at that held address, and shows a later write to it without a new read.
- R7: When both clocks are tied together and a read and a write to the same address are presented in the same cycle, the read returns the old contents in either variant.
- R8: While `rstN` is low, the enable and address registers are cleared. In the `PSEUDO_ASYNC = 0` variant `rdData` is zero. The array contents are not cleared.
- R9: `ADDR_W` (default 8) sets the depth, as 2 to the power `ADDR_W` words. `DATA_W` (default 16) sets the word width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rstN | input | 1 | Asynchronous active-low reset of the control and address registers |
| wrClk | input | 1 | Write-side clock |
| wrEn | input | 1 | Write request, sampled on rising `wrClk` |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | DATA_W | Write data |
| rdClk | input | 1 | Read-side clock |
| rdEn | input | 1 | Read request, sampled on the capturing edge of `rdClk` |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | DATA_W | Read data |

## Verification
The hardest case to reach is the collision in R7. A read and a write to one address must fall in the same cycle of a shared clock, and the read must sample while the write is still in its input register. The bench drives both requests in one cycle and samples the half-cycle variant before the next rising edge. It samples the registered variant after its second edge, and both must show the old word. A second hard case is R6. The falling-edge variant has to be shown updating with no new read issued. The bench parks the read address with `rdEn` low, writes that address, and watches the output change. It also gates the read clock off to show that read-port activity goes nowhere while writes still land.

// File: rtl/split_ram_pkg.sv
package split_ram_pkg;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic wrCapture;  // load write address/data input registers
    logic wrCommit;   // write the input registers into the array
    logic rdCapture;  // load the read address register
    logic rdLoad;     // load the read output register (registered variant)
  } ramStrobes_t;

endpackage

// File: rtl/split_ram_ctrl.sv
module split_ram_ctrl
  import split_ram_pkg::*;
#(
  parameter bit PSEUDO_ASYNC = 1'b0
) (
  input  logic        rstN,
  input  logic        wrClk,
  input  logic        wrEn,
  input  logic        rdClk,
  input  logic        rdEn,
  output ramStrobes_t strb
);

  logic wrEnQ;
  logic rdEnQ;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) wrEnQ <= 1'b0;
    else       wrEnQ <= wrEn;
  end

  generate
    if (PSEUDO_ASYNC) begin : gPaEnable
      // Enable is captured on the falling edge, together with the address
      always_ff @(negedge rdClk or negedge rstN) begin
        if (!rstN) rdEnQ <= 1'b0;
        else       rdEnQ <= rdEn;
      end
    end else begin : gSyncEnable
      always_ff @(posedge rdClk or negedge rstN) begin
        if (!rstN) rdEnQ <= 1'b0;
        else       rdEnQ <= rdEn;
      end
    end
  endgenerate

  always_comb begin
    strb.wrCapture = wrEn;
    strb.wrCommit  = wrEnQ;
    strb.rdCapture = rdEn;
    strb.rdLoad    = PSEUDO_ASYNC ? 1'b0 : rdEnQ;
  end

endmodule

// File: rtl/split_ram_dp.sv
module split_ram_dp
  import split_ram_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 16,
  parameter bit PSEUDO_ASYNC = 1'b0
) (
  input  logic              rstN,
  input  logic              wrClk,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdClk,
  input  logic [ADDR_W-1:0] rdAddr,
  input  ramStrobes_t       strb,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wrAddrQ;
  logic [DATA_W-1:0] wrDataQ;
  logic [ADDR_W-1:0] rdAddrQ;

  // Write input registers
  always_ff @(posedge wrClk) begin
    if (strb.wrCapture) begin
      wrAddrQ <= wrAddr;
      wrDataQ <= wrData;
    end
  end

  // Array write one edge after capture
  always_ff @(posedge wrClk) begin
    if (strb.wrCommit) mem[wrAddrQ] <= wrDataQ;
  end

  generate
    if (PSEUDO_ASYNC) begin : gPaRead
      always_ff @(negedge rdClk or negedge rstN) begin
        if (!rstN)               rdAddrQ <= '0;
        else if (strb.rdCapture) rdAddrQ <= rdAddr;
      end
      // Output register bypassed: data follows the array
      always_comb rdData = mem[rdAddrQ];
    end else begin : gSyncRead
      logic [DATA_W-1:0] rdDataQ;
      always_ff @(posedge rdClk or negedge rstN) begin
        if (!rstN)               rdAddrQ <= '0;
        else if (strb.rdCapture) rdAddrQ <= rdAddr;
      end
      always_ff @(posedge rdClk or negedge rstN) begin
        if (!rstN)            rdDataQ <= '0;
        else if (strb.rdLoad) rdDataQ <= mem[rdAddrQ];
      end
      always_comb rdData = rdDataQ;
    end
  endgenerate

endmodule

// File: rtl/split_clock_ram.sv
module split_clock_ram
  import split_ram_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 16,
  parameter bit PSEUDO_ASYNC = 1'b0
) (
  input  logic              rstN,
  input  logic              wrClk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdClk,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);

  ramStrobes_t strb;

  split_ram_ctrl #(.PSEUDO_ASYNC(PSEUDO_ASYNC)) ctrl (
    .rstN  (rstN),
    .wrClk (wrClk),
    .wrEn  (wrEn),
    .rdClk (rdClk),
    .rdEn  (rdEn),
    .strb  (strb)
  );

  split_ram_dp #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .PSEUDO_ASYNC (PSEUDO_ASYNC)
  ) dp (
    .rstN   (rstN),
    .wrClk  (wrClk),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdClk  (rdClk),
    .rdAddr (rdAddr),
    .strb   (strb),
    .rdData (rdData)
  );

endmodule

// File: rtl/split_ram_chk.sv
module split_ram_chk #(
  parameter int DATA_W       = 16,
  parameter bit PSEUDO_ASYNC = 1'b0
) (
  input logic              rstN,
  input logic              wrClk,
  input logic              wrEn,
  input logic              rdClk,
  input logic              rdEn,
  input logic [DATA_W-1:0] rdData,
  input logic              wrCommit,
  input logic              rdLoad
);

  logic [1:0] rdCnt;
  logic [1:0] wrCnt;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)              rdCnt <= '0;
    else if (rdCnt != 2'd3) rdCnt <= rdCnt + 2'd1;
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN)              wrCnt <= '0;
    else if (wrCnt != 2'd3) wrCnt <= wrCnt + 2'd1;
  end

  AST_WR_NEEDS_REQ: assert property (@(posedge wrClk) disable iff (!rstN)
    (wrCnt >= 2'd1 && wrCommit) |-> $past(wrEn)) else $error("commit without request"); // R1

  generate
    if (!PSEUDO_ASYNC) begin : gSyncChecks
      AST_HOLD_WITHOUT_EN: assert property (@(posedge rdClk) disable iff (!rstN)
        (rdCnt == 2'd3 && !$past(rdEn, 2)) |-> $stable(rdData)) else $error("output moved"); // R5

      AST_LOAD_NEEDS_EN: assert property (@(posedge rdClk) disable iff (!rstN)
        (rdCnt >= 2'd1 && rdLoad) |-> $past(rdEn)) else $error("load without enable"); // R3

      always @(posedge rdClk) begin
        if (!rstN) begin
          AST_RESET_ZERO: assert (rdData == '0) else $error("output not cleared"); // R8
        end
      end
    end else begin : gPaChecks
      AST_NO_OUTPUT_LOAD: assert property (@(posedge rdClk) disable iff (!rstN)
        !rdLoad) else $error("output register used"); // R4
    end
  endgenerate

endmodule

bind split_clock_ram split_ram_chk #(
  .DATA_W       (DATA_W),
  .PSEUDO_ASYNC (PSEUDO_ASYNC)
) chk (
  .rstN     (rstN),
  .wrClk    (wrClk),
  .wrEn     (wrEn),
  .rdClk    (rdClk),
  .rdEn     (rdEn),
  .rdData   (rdData),
  .wrCommit (strb.wrCommit),
  .rdLoad   (strb.rdLoad)
);

// File: tb/split_clock_ram_test.sv
module split_clock_ram_test;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int NVEC   = 10;
  // {isWrite, addr[7:0], data[15:0]}
  localparam logic [24:0] VEC [NVEC] = '{
    25'h1001234, 25'h1FFABCD, 25'h15A0F0F, 25'h1018001, 25'h0FF0000,
    25'h0000000, 25'h05A0000, 25'h0010000, 25'h15AC3C3, 25'h05A0000
  };

  logic clk = 1'b0;
  logic rdRun = 1'b1;
  logic rdClk;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic rdEn = 1'b0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [DATA_W-1:0] rdDataS;
  logic [DATA_W-1:0] rdDataP;
  logic [DATA_W-1:0] refMem [1 << ADDR_W];
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;  // 50 MHz
  assign rdClk = clk & rdRun;

  split_clock_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PSEUDO_ASYNC(1'b0)) uut (
    .rstN(rstN), .wrClk(clk), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdClk(rdClk), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdDataS)
  );

  split_clock_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PSEUDO_ASYNC(1'b1)) uutPa (
    .rstN(rstN), .wrClk(clk), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdClk(rdClk), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdDataP)
  );

  task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Write lands in the array at the second rising edge; returns right after it
  task automatic writeWord(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(posedge clk); #2;
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); #2;
    wrEn = 1'b0;
    @(posedge clk);
    refMem[a] = d;
  endtask

  task automatic readCheck(input logic [ADDR_W-1:0] a, input string tag);
    logic [DATA_W-1:0] prevS;
    prevS = rdDataS;
    @(posedge clk); #2;
    rdAddr = a; rdEn = 1'b1;
    #16 chk({tag, " R4 half-cycle read"}, rdDataP, refMem[a]);
    @(posedge clk); #2;
    rdEn = 1'b0;
    #16 chk({tag, " R3 not before second edge"}, rdDataS, prevS);
    @(posedge clk); #18;
    chk({tag, " R3 registered read"}, rdDataS, refMem[a]);
  endtask

  initial begin
    #4_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #18 chk("R8 output cleared in reset", rdDataS, '0);
    @(posedge clk); #2;
    rstN = 1'b1;

    // R1 R3 R4 R9: table walk against the reference array
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][24]) writeWord(VEC[i][23:16], VEC[i][15:0]);
      else            readCheck(VEC[i][23:16], "R1 table");
    end

    // R5/R6: enable low, address moved; both hold 0x5A contents
    @(posedge clk); #2;
    rdAddr = 8'hFF; rdEn = 1'b0;
    repeat (3) @(posedge clk);
    #18 chk("R5 registered hold", rdDataS, 16'hC3C3);
    chk("R6 held address", rdDataP, 16'hC3C3);

    // R6: write to held address shows on half-cycle output only
    writeWord(8'h5A, 16'h7777);
    #18 chk("R6 follows storage", rdDataP, 16'h7777);
    chk("R5 register unaffected", rdDataS, 16'hC3C3);

    // R7: read and write same address in the same cycle
    readCheck(8'h00, "R7 setup");
    @(posedge clk); #2;
    wrEn = 1'b1; wrAddr = 8'h01; wrData = 16'h2222;
    rdEn = 1'b1; rdAddr = 8'h01;
    #16 chk("R7 half-cycle old data", rdDataP, 16'h8001);
    @(posedge clk); #2;
    wrEn = 1'b0; rdEn = 1'b0;
    @(posedge clk); #18;
    chk("R7 registered old data", rdDataS, 16'h8001);
    refMem[8'h01] = 16'h2222;
    readCheck(8'h01, "R7 new data");

    // R2: stop read clock, read port activity ignored, writes still land
    @(negedge clk); #2;
    rdRun = 1'b0;
    rdAddr = 8'hFF; rdEn = 1'b1;
    writeWord(8'h00, 16'h5555);
    repeat (2) @(posedge clk);
    #18 chk("R2 registered frozen", rdDataS, 16'h2222);
    chk("R2 half-cycle frozen", rdDataP, 16'h2222);
    rdEn = 1'b0;
    @(negedge clk); #2;
    rdRun = 1'b1;
    readCheck(8'hFF, "R2 resumed");
    readCheck(8'h00, "R1 write while read clock off");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule